// File: doc/BRIEF.md
# HDLC Receive Deframer

This block sits behind a bit demodulator and turns a stream of decoded bits into an HDLC byte stream. Each bit comes with a one-cycle strobe. The block keeps the last eight bits in a history register. From that history it finds flags and abort patterns, and it drops the zero bits that a transmitter inserts after five ones. The remaining bits are packed into bytes, least significant bit first. Every flag and every data byte goes into one 16-entry byte FIFO that the downstream framing logic reads.

Flags, escapes and data share that single stream. A flag shows up in the stream as the byte 0x7E. A data byte whose value could be mistaken for a control code (0x7E, 0x7F or 0x1B) is written as 0x1B followed by the byte itself. The consumer therefore sees frame boundaries and payload in order, with no sideband.

Two level indicators report link state. One shows that a flag has opened reception. The other is a carrier indication that follows a run of flags. A FIFO overflow gives a one-cycle error pulse and drops reception until the next flag.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A strobed bit that makes the last eight received bits equal 0x7E (newest bit in the least significant position) writes the byte 0x7E into the FIFO and sets receiving_o, in the same clock edge as the strobe.
- R2: carrier_o goes high at the third successfully written flag since the last abort, overflow or reset. carrier_o is never high while receiving_o is low.
- R3: While receiving, every eight kept bits after a flag form one data byte, first received bit in bit 0. The byte is written into the FIFO at the edge of its eighth bit. A flag clears any partial byte.
- R4: While receiving, a 0 bit that follows five consecutive 1 bits is dropped and does not count toward the byte.
- R5: A completed data byte equal to 0x7E, 0x7F or 0x1B is written as two entries, 0x1B first and then the byte.
- R6: Seven consecutive 1 bits clear receiving_o and carrier_o. Bits after that write nothing until the next flag.
- R7: Before the first flag, bits write nothing into the FIFO and receiving_o stays low.
- R8: If a needed FIFO write finds no space, overflow_o pulses high for one cycle and receiving_o and carrier_o clear. Entries already in the FIFO stay. For an escaped byte, the 0x1B is still written when exactly one slot is free.
- R9: With bit_valid_i low, bit_i has no effect on any output.
- R10: The FIFO holds 16 entries and shows its oldest entry on rd_data_o while rd_empty_o is low. rd_en_i removes that entry. rd_en_i while empty has no effect.
- R11: After reset, receiving_o, carrier_o and overflow_o are low and rd_empty_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_valid_i | input | 1 | Strobe: bit_i holds a new decoded bit |
| bit_i | input | 1 | Decoded bit |
| rd_en_i | input | 1 | Remove the oldest FIFO entry |
| rd_data_o | output | 8 | Oldest FIFO entry |
| rd_empty_o | output | 1 | FIFO holds no entries |
| receiving_o | output | 1 | A flag has opened reception |
| carrier_o | output | 1 | Three or more flags seen in the current reception |
| overflow_o | output | 1 | One-cycle pulse: a write was lost because the FIFO was full |

## Verification
Every result here belongs to the clock edge that samples the strobed bit. That includes the flag entry, the data byte, the escape pair, the level changes on receiving_o and carrier_o, and the overflow pulse. A FIFO entry is visible on rd_data_o right after that edge, and a read takes effect at the edge where rd_en_i is high. The bench drives each strobe from one falling edge to the next, so exactly one rising edge falls inside it. It samples the indicators and the overflow pulse at that next falling edge, which is half a cycle after the edge that updated them and before the pulse can clear. It reads FIFO contents only after a stimulus sequence has finished, comparing them in order against a queue of bytes built from the requirements.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E;
    localparam logic [BYTE_W-1:0] ABORT_MASK = 8'h7F;
    localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h1B;
    localparam logic [BYTE_W-1:0] STUFF_MASK = 8'h3F;
    localparam logic [BYTE_W-1:0] STUFF_PAT  = 8'h3E;

    // A data byte that the consumer could mistake for a control code.
    function automatic logic is_ctrl(input logic [BYTE_W-1:0] b);
        return (b == FLAG_CODE) || (b == ABORT_MASK) || (b == ESC_CODE);
    endfunction
endpackage

// File: rtl/hdlc_rx_parser.sv
module hdlc_rx_parser
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned CARRIER_FLAGS = 3,
    parameter int unsigned SPACE_W       = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bit_valid_i,
    input  logic                bit_i,
    input  logic [SPACE_W-1:0]  space_i,
    output logic [1:0]          wr_cnt_o,
    output logic [BYTE_W-1:0]   wr_b0_o,
    output logic [BYTE_W-1:0]   wr_b1_o,
    output logic                receiving_o,
    output logic                carrier_o,
    output logic                overflow_o
);
    localparam int unsigned IDX_W = $clog2(BYTE_W);
    localparam int unsigned CNT_W = $clog2(CARRIER_FLAGS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(CARRIER_FLAGS);

    typedef struct packed {
        logic [BYTE_W-1:0] hist;
        logic [BYTE_W-1:0] acc;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  flags;
        logic              rx;
        logic              ovf;
    } state_t;

    state_t s_d, s_q;

    logic [BYTE_W-1:0] hist_n;
    logic [BYTE_W-1:0] acc_n;
    logic [1:0]        need;
    logic [BYTE_W-1:0] b0, b1;
    logic              fits;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        need    = 2'd0;
        b0      = '0;
        b1      = '0;
        hist_n  = {s_q.hist[BYTE_W-2:0], bit_i};
        acc_n   = s_q.acc | {bit_i, {(BYTE_W-1){1'b0}}};

        if (bit_valid_i) begin
            s_d.hist = hist_n;
            if (hist_n == FLAG_CODE) begin
                // Flag: resynchronise byte assembly, emit a marker.
                s_d.acc = '0;
                s_d.idx = '0;
                need    = 2'd1;
                b0      = FLAG_CODE;
                s_d.rx  = 1'b1;
                if (s_q.flags < CNT_MAX) begin
                    s_d.flags = s_q.flags + 1'b1;
                end
            end else if ((hist_n & ABORT_MASK) == ABORT_MASK) begin
                // Abort pattern or idle ones.
                s_d.rx    = 1'b0;
                s_d.flags = '0;
            end else if (s_q.rx && ((hist_n & STUFF_MASK) != STUFF_PAT)) begin
                if (s_q.idx == LAST_IDX) begin
                    s_d.acc = '0;
                    s_d.idx = '0;
                    if (is_ctrl(acc_n)) begin
                        need = 2'd2;
                        b0   = ESC_CODE;
                        b1   = acc_n;
                    end else begin
                        need = 2'd1;
                        b0   = acc_n;
                    end
                end else begin
                    s_d.acc = acc_n >> 1;
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end

        fits = ({{(SPACE_W-2){1'b0}}, need} <= space_i);
        if ((need != 2'd0) && !fits) begin
            s_d.rx    = 1'b0;
            s_d.flags = '0;
            s_d.ovf   = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_cnt_o    = fits ? need : space_i[1:0];
    assign wr_b0_o     = b0;
    assign wr_b1_o     = b1;
    assign receiving_o = s_q.rx;
    assign carrier_o   = (s_q.flags >= CNT_MAX);
    assign overflow_o  = s_q.ovf;
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        wr_cnt_i,
    input  logic [WIDTH-1:0]  wr_d0_i,
    input  logic [WIDTH-1:0]  wr_d1_i,
    input  logic              rd_en_i,
    output logic [WIDTH-1:0]  rd_data_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  space_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             pop;
    logic [PTR_W-1:0] wp_next;

    always_comb begin
        p_d     = p_q;
        pop     = rd_en_i && (p_q.cnt != '0);
        wp_next = p_q.wp + 1'b1;
        p_d.wp  = p_q.wp + PTR_W'(wr_cnt_i);
        if (pop) begin
            p_d.rp = p_q.rp + 1'b1;
        end
        p_d.cnt = p_q.cnt + CNT_W'(wr_cnt_i) - CNT_W'(pop);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (wr_cnt_i != 2'd0) begin
            mem[p_q.wp] <= wr_d0_i;
        end
        if (wr_cnt_i == 2'd2) begin
            mem[wp_next] <= wr_d1_i;
        end
    end

    assign rd_data_o = mem[p_q.rp];
    assign empty_o   = (p_q.cnt == '0);
    assign space_o   = CNT_W'(DEPTH) - p_q.cnt;
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH    = 16,
    parameter int unsigned CARRIER_FLAGS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              rd_empty_o,
    output logic              receiving_o,
    output logic              carrier_o,
    output logic              overflow_o
);
    localparam int unsigned SPACE_W = $clog2(FIFO_DEPTH + 1);

    logic [SPACE_W-1:0] space;
    logic [1:0]         wr_cnt;
    logic [BYTE_W-1:0]  wr_b0, wr_b1;

    hdlc_rx_parser #(
        .CARRIER_FLAGS(CARRIER_FLAGS),
        .SPACE_W      (SPACE_W)
    ) i_parser (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_valid_i(bit_valid_i),
        .bit_i      (bit_i),
        .space_i    (space),
        .wr_cnt_o   (wr_cnt),
        .wr_b0_o    (wr_b0),
        .wr_b1_o    (wr_b1),
        .receiving_o(receiving_o),
        .carrier_o  (carrier_o),
        .overflow_o (overflow_o)
    );

    hdlc_rx_fifo #(
        .DEPTH(FIFO_DEPTH),
        .WIDTH(BYTE_W),
        .CNT_W(SPACE_W)
    ) i_fifo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_cnt_i (wr_cnt),
        .wr_d0_i  (wr_b0),
        .wr_d1_i  (wr_b1),
        .rd_en_i  (rd_en_i),
        .rd_data_o(rd_data_o),
        .empty_o  (rd_empty_o),
        .space_o  (space)
    );
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bit_valid_i,
    input logic       bit_i,
    input logic       rd_en_i,
    input logic [7:0] rd_data_o,
    input logic       rd_empty_o,
    input logic       receiving_o,
    input logic       carrier_o,
    input logic       overflow_o
);
    // R2: carrier only inside an open reception
    a_r2_carrier_in_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        carrier_o |-> receiving_o);

    // R2: carrier can only appear after a strobed bit
    a_r2_carrier_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(carrier_o) |-> $past(bit_valid_i));

    // R1: opening reception always leaves a flag entry in the FIFO
    a_r1_flag_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(receiving_o) |-> !rd_empty_o);

    // R8: an overflow closes the reception
    a_r8_overflow_drops_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |-> (!receiving_o && !carrier_o));

    // R9: no strobe, no change
    a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_valid_i |=> ($stable(receiving_o) && $stable(carrier_o) && !overflow_o));

    // R9 / R10: FIFO untouched without strobe or read
    a_r9_fifo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bit_valid_i && !rd_en_i) |=> ($stable(rd_empty_o) && $stable(rd_data_o)));

    // R10: reading an empty FIFO leaves it empty
    a_r10_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && rd_empty_o && !bit_valid_i) |=> rd_empty_o);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_valid_i(bit_valid_i),
    .bit_i      (bit_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .rd_empty_o (rd_empty_o),
    .receiving_o(receiving_o),
    .carrier_o  (carrier_o),
    .overflow_o (overflow_o)
);

// File: tb/test_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module test_hdlc_rx_deframer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_in = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_empty, receiving, carrier, overflow;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   ones_run = 0;
    bit   ovf_seen = 1'b0;
    bit   done     = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bit_valid_i(bit_valid),
        .bit_i      (bit_in),
        .rd_en_i    (rd_en),
        .rd_data_o  (rd_data),
        .rd_empty_o (rd_empty),
        .receiving_o(receiving),
        .carrier_o  (carrier),
        .overflow_o (overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // one strobe from falling edge to falling edge
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in    = b;
        @(negedge clk);
        bit_valid = 1'b0;
        if (overflow) ovf_seen = 1'b1;
    endtask

    task automatic send_raw(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic send_flag();
        send_raw(8'h7E);
        ones_run = 0;
    endtask

    task automatic send_data(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i]);
            ones_run = b[i] ? ones_run + 1 : 0;
            if (ones_run == 5) begin
                send_bit(1'b0);
                ones_run = 0;
            end
        end
    endtask

    function automatic void expect_data(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7F || b == 8'h1B) exp_q.push_back(8'h1B);
        exp_q.push_back(b);
    endfunction

    task automatic drain(input string req);
        int n = 0;
        while (!rd_empty && n < 40) begin
            if (exp_q.size() == 0) begin
                check(1'b0, req, rd_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, req, rd_data, e);
            end
            @(negedge clk); rd_en = 1'b1;
            @(negedge clk); rd_en = 1'b0;
            n++;
        end
        check(exp_q.size() == 0, {req, " entry count"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic t_reset();
        check(!receiving && !carrier && !overflow, "R11 indicators", {receiving, carrier, overflow}, 0);
        check(rd_empty, "R11 empty", rd_empty, 1);
    endtask

    task automatic t_before_flag();
        send_raw(8'hA5);
        send_raw(8'h3C);
        check(rd_empty, "R7 no output", rd_empty, 1);
        check(!receiving, "R7 receiving", receiving, 0);
    endtask

    task automatic t_flags();
        send_flag(); exp_q.push_back(8'h7E);
        check(receiving, "R1 receiving", receiving, 1);
        check(!carrier, "R2 carrier after 1", carrier, 0);
        send_flag(); exp_q.push_back(8'h7E);
        check(!carrier, "R2 carrier after 2", carrier, 0);
        send_flag(); exp_q.push_back(8'h7E);
        check(carrier, "R2 carrier after 3", carrier, 1);
        drain("R1 flag entries");
    endtask

    task automatic t_data();
        send_data(8'h41); expect_data(8'h41);
        send_data(8'hF8); expect_data(8'hF8);
        send_data(8'hFF); expect_data(8'hFF);
        send_flag();      exp_q.push_back(8'h7E);
        drain("R3 R4 data bytes");
    endtask

    task automatic t_ctrl();
        send_data(8'h7E); expect_data(8'h7E);
        send_data(8'h7F); expect_data(8'h7F);
        send_data(8'h1B); expect_data(8'h1B);
        send_flag();      exp_q.push_back(8'h7E);
        drain("R5 escaped bytes");
    endtask

    task automatic t_hold();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bit_in = ~bit_in;
        end
        check(receiving && carrier, "R9 levels held", {receiving, carrier}, 3);
        check(rd_empty, "R9 no write", rd_empty, 1);
    endtask

    task automatic t_empty_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check(rd_empty, "R10 empty read", rd_empty, 1);
        send_data(8'h5A); expect_data(8'h5A);
        check(!rd_empty, "R10 write after empty read", rd_empty, 0);
        drain("R10 entry");
    endtask

    task automatic t_abort();
        send_raw(8'hFF);
        check(!receiving && !carrier, "R6 abort", {receiving, carrier}, 0);
        send_raw(8'h41);
        send_raw(8'h42);
        check(rd_empty, "R6 nothing after abort", rd_empty, 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) begin
            send_flag(); exp_q.push_back(8'h7E);
        end
        check(!ovf_seen, "R10 16 entries fit", ovf_seen, 0);
        send_flag();
        check(ovf_seen, "R8 flag overflow pulse", ovf_seen, 1);
        check(!receiving && !carrier, "R8 flag overflow drops rx", {receiving, carrier}, 0);
        drain("R8 contents kept");
        ovf_seen = 1'b0;
        for (int i = 0; i < 15; i++) begin
            send_flag(); exp_q.push_back(8'h7E);
        end
        check(carrier && !ovf_seen, "R8 15 flags ok", {carrier, ovf_seen}, 2);
        send_data(8'h7E); exp_q.push_back(8'h1B);
        check(ovf_seen, "R8 escape overflow pulse", ovf_seen, 1);
        check(!receiving && !carrier, "R8 escape overflow drops rx", {receiving, carrier}, 0);
        @(negedge clk);
        check(!overflow, "R8 single-cycle pulse", overflow, 0);
        drain("R8 partial escape");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_before_flag();
        t_flags();
        t_data();
        t_ctrl();
        t_hold();
        t_empty_read();
        t_abort();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule